// File: doc/BRIEF.md
# In-system programming entry sequencer

This block is a host-side controller that puts a target device into its serial programming mode. When it receives a start command it drives the target's reset line and serial clock low. It then gives reset a short high pulse and waits a settle period. After that it clocks out a four-byte programming-enable instruction, most significant bit first, on a serial data line. While the third byte is being shifted, it checks the byte that the target returns on its data-out line.

A correct echo ends the entry with a one-cycle done pulse, and the block returns to idle with reset held low. A wrong echo does not cut the instruction short: all 32 bits are still sent. The sequencer then pulses reset again to resynchronise, waits the settle time and reissues the instruction. After a parameterised number of failed attempts it raises a fail flag and halts until the next start. The SCK half-period, reset pulse length and settle delay are all counted in system clock cycles.

The states are ST_IDLE, ST_PRE (reset and SCK low), ST_PULSE (reset high), ST_SETTLE, ST_SHIFT, ST_EVAL, ST_DONE and ST_HALT. The transitions are:
- ST_IDLE or ST_HALT to ST_PRE on start.
- ST_PRE to ST_PULSE, ST_PULSE to ST_SETTLE and ST_SETTLE to ST_SHIFT, each when its timer expires.
- ST_SHIFT to ST_EVAL after the 32nd falling SCK edge.
- ST_EVAL to ST_DONE on a matching echo.
- ST_EVAL to ST_PULSE on a mismatch while attempts remain.
- ST_EVAL to ST_HALT on a mismatch in the last attempt.
- ST_DONE to ST_IDLE after one cycle.

Top module: `isp_entry_seq`

## Requirements
- R1: After reset, and in idle, tgt_rst, sck, mosi, busy, done and fail are all 0.
- R2: A start accepted in idle holds tgt_rst and sck low for PULSE_CYC cycles and then drives tgt_rst high for PULSE_CYC cycles, with sck low; busy is 1 from the cycle after start.
- R3: After each reset pulse, tgt_rst, sck and mosi stay low for SETTLE_CYC cycles before the first SCK phase.
- R4: The instruction bytes 0xAC, 0x53, 0x00, 0x00 are sent in that order, each MSB first. Each bit is placed on mosi at the start of its SCK low phase and held until that bit's falling edge.
- R5: Every SCK low phase and every high phase of the instruction lasts exactly HALF_CYC system cycles, and there are 32 cycles of SCK per attempt.
- R6: miso is sampled at each rising SCK edge. The eight samples of instruction bits 16 to 23 (the third byte), taken MSB first, form the echo, and it matches only when it equals 0x53.
- R7: All 32 bits are sent whether or not the echo matches.
- R8: On a match, done is high for exactly one cycle, two cycles after the last falling SCK edge, and the block then returns to idle.
- R9: On a mismatch with attempts left, a new reset pulse of PULSE_CYC cycles begins two cycles after the last falling edge, followed by the settle time and a full new instruction.
- R10: After MAX_TRIES consecutive mismatches, fail goes high and busy low, with tgt_rst and sck low, and this holds until the next start.
- R11: start has no effect while busy is high.
- R12: A start while fail is high clears fail and begins a new entry with the full MAX_TRIES attempts available.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer |
| start | input | 1 | Command to begin the entry sequence (sampled in idle or halt) |
| miso | input | 1 | Serial data returned by the target |
| tgt_rst | output | 1 | Level driven on the target's reset line (1 = high) |
| sck | output | 1 | Serial clock to the target |
| mosi | output | 1 | Serial data to the target |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle pulse: echo matched, target in programming mode |
| fail | output | 1 | Held high after all attempts failed |

## Verification
The hardest situation to reach from the ports is a restart from the halted state, where the attempt count must start fresh. A design that keeps the old count would halt after one more mismatch instead of retrying. To reach it, the bench's target model returns echoes from a scripted list. The list contains three bad echoes in a row to force the halt, then a bad echo followed by a good one after the restart. Near-miss echoes that differ from 0x53 by a single bit show that the whole third byte is compared, bit by bit, in MSB-first order.

// File: rtl/isp_entry_pkg.sv
package isp_entry_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_PULSE,
        ST_SETTLE,
        ST_SHIFT,
        ST_EVAL,
        ST_DONE,
        ST_HALT
    } seq_state_t;

    localparam int unsigned INSTR_BITS  = 32;
    localparam int unsigned BYTE_BITS   = 8;
    localparam logic [31:0] ENABLE_WORD = 32'hAC53_0000;
    localparam logic [7:0]  SYNC_ECHO   = 8'h53;
    localparam int unsigned ECHO_SLOT   = 2;   // third byte, counted from zero

endpackage

// File: rtl/isp_timer.sv
module isp_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/isp_sck_gen.sv
module isp_sck_gen #(
    parameter  int unsigned HALF_CYC = 3,
    parameter  int unsigned NBITS    = 32,
    localparam int unsigned PW       = $clog2(HALF_CYC + 1),
    localparam int unsigned BW       = $clog2(NBITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic          sck,
    output logic          rise,
    output logic          fall,
    output logic          last,
    output logic [BW-1:0] bit_idx
);

    logic [PW-1:0] ph_q;
    logic          sck_q;
    logic [BW-1:0] bit_q;
    logic          flip;

    assign flip = run && (ph_q == PW'(HALF_CYC - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ph_q  <= '0;
            sck_q <= 1'b0;
            bit_q <= '0;
        end else if (flip) begin
            ph_q  <= '0;
            sck_q <= ~sck_q;
            if (sck_q) begin
                bit_q <= bit_q + 1'b1;
            end
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    assign sck     = sck_q;
    assign rise    = flip && !sck_q;
    assign fall    = flip && sck_q;
    assign last    = fall && (bit_q == BW'(NBITS - 1));
    assign bit_idx = bit_q;

endmodule

// File: rtl/isp_shifter.sv
module isp_shifter #(
    parameter int unsigned NBITS = 32,
    parameter int unsigned RXW   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NBITS-1:0] load_word,
    input  logic             shift,
    input  logic             capture,
    input  logic             miso,
    output logic             mosi_bit,
    output logic [RXW-1:0]   rx_byte
);

    logic [NBITS-1:0] tx_q;
    logic [RXW-1:0]   rx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_word;
        end else if (shift) begin
            tx_q <= {tx_q[NBITS-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            rx_q <= '0;
        end else if (capture) begin
            rx_q <= {rx_q[RXW-2:0], miso};
        end
    end

    assign mosi_bit = tx_q[NBITS-1];
    assign rx_byte  = rx_q;

endmodule

// File: rtl/isp_entry_seq.sv
module isp_entry_seq
    import isp_entry_pkg::*;
#(
    parameter int unsigned HALF_CYC   = 3,
    parameter int unsigned PULSE_CYC  = 2,
    parameter int unsigned SETTLE_CYC = 5_000_000,
    parameter int unsigned MAX_TRIES  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic miso,
    output logic tgt_rst,
    output logic sck,
    output logic mosi,
    output logic busy,
    output logic done,
    output logic fail
);

    localparam int unsigned LONGEST = (SETTLE_CYC > PULSE_CYC) ? SETTLE_CYC : PULSE_CYC;
    localparam int unsigned TW      = $clog2(LONGEST + 1);
    localparam int unsigned AW      = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
    localparam int unsigned BW      = $clog2(INSTR_BITS);
    localparam logic [BW-1:0] ECHO_END_BIT = BW'(ECHO_SLOT * BYTE_BITS + BYTE_BITS - 1);
    localparam logic [TW-1:0] PULSE_LOAD   = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] SETTLE_LOAD  = TW'(SETTLE_CYC - 1);
    localparam logic [AW-1:0] LAST_TRY     = AW'(MAX_TRIES - 1);

    seq_state_t state_q, state_d;

    logic           tmr_load;
    logic [TW-1:0]  tmr_val;
    logic           tmr_zero;
    logic           run;
    logic           sck_int;
    logic           sck_rise;
    logic           sck_fall;
    logic           shift_last;
    logic [BW-1:0]  bit_idx;
    logic           word_load;
    logic           mosi_int;
    logic [7:0]     rx_byte;
    logic [7:0]     echo_q;
    logic           echo_ok;
    logic [AW-1:0]  tries_q;
    logic           last_try;
    logic           accept;

    isp_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    isp_sck_gen #(.HALF_CYC(HALF_CYC), .NBITS(INSTR_BITS)) u_sck (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .sck     (sck_int),
        .rise    (sck_rise),
        .fall    (sck_fall),
        .last    (shift_last),
        .bit_idx (bit_idx)
    );

    isp_shifter #(.NBITS(INSTR_BITS), .RXW(BYTE_BITS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (word_load),
        .load_word (ENABLE_WORD),
        .shift     (sck_fall),
        .capture   (sck_rise),
        .miso      (miso),
        .mosi_bit  (mosi_int),
        .rx_byte   (rx_byte)
    );

    assign run       = (state_q == ST_SHIFT);
    assign word_load = (state_q == ST_SETTLE) && tmr_zero;
    assign accept    = ((state_q == ST_IDLE) || (state_q == ST_HALT)) && start;
    assign echo_ok   = (echo_q == SYNC_ECHO);
    assign last_try  = (tries_q == LAST_TRY);

    // Echo byte is frozen at the falling edge that ends the third byte.
    always_ff @(posedge clk) begin
        if (!rst_n || word_load) begin
            echo_q <= '0;
        end else if (sck_fall && (bit_idx == ECHO_END_BIT)) begin
            echo_q <= rx_byte;
        end
    end

    // Failed-attempt counter, cleared by every accepted start (R12).
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            tries_q <= '0;
        end else if ((state_q == ST_EVAL) && !echo_ok && !last_try) begin
            tries_q <= tries_q + 1'b1;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE, ST_HALT: begin
                if (start) begin
                    state_d  = ST_PRE;
                    tmr_load = 1'b1;
                    tmr_val  = PULSE_LOAD;
                end
            end
            ST_PRE: begin
                if (tmr_zero) begin
                    state_d  = ST_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = PULSE_LOAD;
                end
            end
            ST_PULSE: begin
                if (tmr_zero) begin
                    state_d  = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = SETTLE_LOAD;
                end
            end
            ST_SETTLE: begin
                if (tmr_zero) begin
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (shift_last) begin
                    state_d = ST_EVAL;
                end
            end
            ST_EVAL: begin
                if (echo_ok) begin
                    state_d = ST_DONE;
                end else if (last_try) begin
                    state_d = ST_HALT;
                end else begin
                    state_d  = ST_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = PULSE_LOAD;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        tgt_rst = 1'b0;
        sck     = 1'b0;
        mosi    = 1'b0;
        busy    = 1'b0;
        done    = 1'b0;
        fail    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_PRE, ST_SETTLE, ST_EVAL: begin
                busy = 1'b1;
            end
            ST_PULSE: begin
                busy    = 1'b1;
                tgt_rst = 1'b1;
            end
            ST_SHIFT: begin
                busy = 1'b1;
                sck  = sck_int;
                mosi = mosi_int;
            end
            ST_DONE: begin
                busy = 1'b1;
                done = 1'b1;
            end
            ST_HALT: begin
                fail = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/isp_entry_seq_chk.sv
module isp_entry_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic tgt_rst,
    input logic sck,
    input logic mosi,
    input logic busy,
    input logic done,
    input logic fail
);

    // R1 / R10: no clock activity when the sequencer is not running
    a_r10_sck_quiet_when_not_busy: assert property (
        @(posedge clk) disable iff (!rst_n) !busy |-> !sck
    );

    // R2: SCK is low throughout a reset pulse
    a_r2_sck_low_during_pulse: assert property (
        @(posedge clk) disable iff (!rst_n) tgt_rst |-> !sck
    );

    // R4: data does not move while the clock is high
    a_r4_mosi_steady_while_high: assert property (
        @(posedge clk) disable iff (!rst_n) sck |-> $stable(mosi)
    );

    // R5: no single-cycle high phase
    a_r5_high_phase_min: assert property (
        @(posedge clk) disable iff (!rst_n) $rose(sck) |=> sck
    );

    // R5: no single-cycle low phase after a fall
    a_r5_low_phase_min: assert property (
        @(posedge clk) disable iff (!rst_n) $fell(sck) |=> !sck
    );

    // R8: done is a one-cycle pulse
    a_r8_done_single_cycle: assert property (
        @(posedge clk) disable iff (!rst_n) done |=> !done
    );

    // R8 / R10: success and failure never together
    a_r8_done_excludes_fail: assert property (
        @(posedge clk) disable iff (!rst_n) !(done && fail)
    );

    // R10: fail holds until a new start
    a_r10_fail_sticky: assert property (
        @(posedge clk) disable iff (!rst_n) (fail && !start) |=> fail
    );

    // R12: a start in the halted state clears fail and begins work
    a_r12_restart_from_fail: assert property (
        @(posedge clk) disable iff (!rst_n) (fail && start) |=> (busy && !fail)
    );

endmodule

bind isp_entry_seq isp_entry_seq_chk u_chk (.*);

// File: tb/sim_isp_entry_seq.sv
module sim_isp_entry_seq;

    localparam int unsigned H  = 3;
    localparam int unsigned PC = 2;
    localparam int unsigned SC = 20;
    localparam int unsigned MT = 3;
    localparam logic [31:0] ENABLE = 32'hAC53_0000;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic miso;
    logic tgt_rst, sck, mosi, busy, done, fail;

    int n_cmp = 0;
    int n_bad = 0;

    isp_entry_seq #(
        .HALF_CYC   (H),
        .PULSE_CYC  (PC),
        .SETTLE_CYC (SC),
        .MAX_TRIES  (MT)
    ) u0 (.*);

    always #2 clk = ~clk;

    // Scripted echoes, one per attempt, in attempt order
    logic [7:0] echoes [0:8] = '{8'h53, 8'h00, 8'h52, 8'h53, 8'hFF, 8'hD3, 8'h13, 8'h5B, 8'h53};

    // ---------------- target model ----------------
    int         t_att   = 0;
    int         t_falls = 0;
    int         t_rises = 0;
    logic [7:0] t_echo  = 8'h00;

    always @(posedge tgt_rst) begin
        t_echo  = echoes[t_att];
        t_att   = t_att + 1;
        t_falls = 0;
        t_rises = 0;
    end
    always @(negedge sck) t_falls = t_falls + 1;
    always @(posedge sck) t_rises = t_rises + 1;

    assign miso = (t_falls >= 16 && t_falls < 24) ? t_echo[3'(23 - t_falls)] : 1'b0;

    // ---------------- reference model ----------------
    logic  e_rst = 0, e_sck = 0, e_mosi = 0, e_busy = 0, e_done = 0, e_fail = 0;
    string phase  = "R1";
    int    m_att  = 0;
    bit    m_halt = 0;
    bit    wd_hit = 0;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(logic r, logic s, logic m, logic b, logic d, logic f);
        e_rst = r; e_sck = s; e_mosi = m; e_busy = b; e_done = d; e_fail = f;
    endtask

    task automatic note(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic session(string retry_tag);
        int tries = 0;
        phase = "R2";
        repeat (PC) begin drive(0, 0, 0, 1, 0, 0); step(); end
        forever begin
            phase = (tries == 0) ? "R2" : retry_tag;
            repeat (PC) begin drive(1, 0, 0, 1, 0, 0); step(); end
            phase = "R3";
            repeat (SC) begin drive(0, 0, 0, 1, 0, 0); step(); end
            for (int k = 0; k < 32; k++) begin
                logic b;
                b = ENABLE[31 - k];
                phase = "R4";
                repeat (H) begin drive(0, 0, b, 1, 0, 0); step(); end
                phase = "R5";
                repeat (H) begin drive(0, 1, b, 1, 0, 0); step(); end
            end
            phase = "R6";
            drive(0, 0, 0, 1, 0, 0);
            note(t_rises == 32, "R7 rising edges per attempt", t_rises, 32);
            step();
            if (echoes[m_att] == 8'h53) begin
                m_att++;
                phase = "R8";
                drive(0, 0, 0, 1, 1, 0);
                step();
                return;
            end
            m_att++;
            tries++;
            if (tries == MT) begin
                m_halt = 1;
                return;
            end
        end
    endtask

    initial begin
        forever begin
            drive(0, 0, 0, 0, 0, m_halt);
            phase = m_halt ? "R10" : "R1";
            step();
            if (rst_n && start) begin
                string tag;
                tag    = m_halt ? "R12" : "R9";
                m_halt = 0;
                session(tag);
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (!wd_hit) begin
            n_cmp++;
            if ({tgt_rst, sck, mosi, busy, done, fail} !== {e_rst, e_sck, e_mosi, e_busy, e_done, e_fail}) begin
                n_bad++;
                $display("FAIL %s: rst/sck/mosi/busy/done/fail actual %b expected %b at %0t", phase,
                         {tgt_rst, sck, mosi, busy, done, fail},
                         {e_rst, e_sck, e_mosi, e_busy, e_done, e_fail}, $time);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic kick();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        note({tgt_rst, sck, mosi, busy, done, fail} == 6'b0, "R1 idle outputs",
             int'({tgt_rst, sck, mosi, busy, done, fail}), 0);

        // Session 1: good echo on first try; a second start mid-shift is ignored (R11)
        kick();
        repeat (100) @(negedge clk);
        kick();
        wait_idle();
        repeat (60) @(negedge clk);
        note(busy == 1'b0, "R11 start while busy ignored", int'(busy), 0);
        note(t_att == 1, "R11 attempts after ignored start", t_att, 1);

        // Session 2: two bad echoes then a good one (R9)
        kick();
        wait_idle();
        repeat (10) @(negedge clk);
        note(t_att == 4, "R9 attempts in retry session", t_att, 4);

        // Session 3: three bad echoes, halts with fail (R10)
        kick();
        wait_idle();
        repeat (40) @(negedge clk);
        note(fail == 1'b1, "R10 fail held", int'(fail), 1);

        // Session 4: restart from halt, bad then good (R12)
        kick();
        wait_idle();
        repeat (10) @(negedge clk);
        note(fail == 1'b0, "R12 fail cleared after restart", int'(fail), 0);
        note(t_att == 9, "R12 attempts after restart", t_att, 9);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        wd_hit = 1;
        n_cmp++;
        n_bad++;
        $display("FAIL R8 watchdog: actual still running, expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule